// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two event counters of parameterised width (32 bits by default), called the even lane and the odd lane. Each lane has its own event-type selector, a sticky enable bit and an overflow flag. A counter can count cycle ticks or software-increment pulses. The odd lane can also be given the chain type. It then counts the carries out of the even lane, so that the pair acts as one counter of twice the width.

A master run input gates all counting. A software-increment strobe carries a per-lane mask. A small register port lets software preset each count, set each event type, set the enable bits and read or clear the overflow flags. The read side is combinational, with its own address. The carry from the even lane reaches the odd lane in the same clock cycle as the wrap, so a read of both halves always shows a consistent double-width value.

When the odd lane is chained, a wrap of the even lane no longer raises the even overflow flag. Only a wrap of the full double-width value is reported, on the odd flag.

Top module: `evtcnt_pair`

## Requirements
- R1: Under synchronous active-low reset, both counts, both event types (value 0x00), both enable bits and both overflow flags become zero, and all six readable addresses read 0.
- R2: A count changes by counting only while `run_en` is 1 and the lane's enable bit is 1. Increment pulses given while `run_en` is 0, or to a disabled lane, leave the count unchanged.
- R3: Event code 0x11 counts one per cycle with `cycle_tick` high. Code 0x00 counts software increments. Code 0x1E selects chain. Any other code counts nothing. The even lane has no lane below it, so chain on the even lane counts nothing.
- R4: A software-increment strobe (`swinc_valid`=1, mask bit 0 for the even lane and bit 1 for the odd lane) adds one to a lane only if its mask bit is 1, the lane is enabled and its type is 0x00.
- R5: With the odd lane not chained, an even wrap from all-ones to 0 sets overflow bit 0. With the even lane preset to 0xFFFFFFF0, 100 strobes of mask 0x3 leave the even lane at 84 and the odd lane at 100, with status 0x1.
- R6: With the odd lane typed chain and enabled, each even wrap adds one to the odd lane in the same edge and does not set overflow bit 0. For example, a preset of 0xFFFFFFF0 plus 22 ticks gives even 6, odd 1 and status 0.
- R7: A chained odd lane that holds all-ones and receives a carry wraps to 0 and sets overflow bit 1, so the status reads 0x2.
- R8: A chained odd lane ignores its software-increment mask bit. With the even lane on type 0x00 preset to 0xFFFFFFF0, 100 strobes of mask 0x3 give even 84, odd 1 and status 0.
- R9: Address 4 is write-1-to-set for the enable bits [1:0]. Writing 0 bits clears nothing, and a read returns the current enables.
- R10: Address 5 reads the overflow flags (bit 0 even, bit 1 odd), and a write clears each flag whose data bit is 1. If a new overflow arrives in the same cycle as the clear, the flag stays set.
- R11: A preset write to a count (address 0 even, 1 odd) wins over any increment or carry in the same cycle. Address 2 and address 3 hold the even and odd types in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Master enable for all counting |
| cycle_tick | input | 1 | Cycle event, counted by lanes of type 0x11 |
| swinc_valid | input | 1 | Software-increment strobe |
| swinc_mask | input | 2 | Per-lane increment mask (bit 0 even, bit 1 odd) |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | CNT_W | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | CNT_W | Combinational read data |

## Verification
The bench builds the block at the default width of 32 bits. This lets the all-ones and 0xFFFFFFF0 preset values be used directly, and the carry and wrap behaviour of the full 64-bit chained value is reached within 22 cycles. Presets near the top of the range bring the even wrap, the chained carry, the double-width wrap and the overflow flags within reach in a few dozen cycles. Same-cycle collisions are driven on purpose: a preset against an increment or a carry, and a status clear against a new overflow.

// File: rtl/evtcnt_pkg.sv
// Shared definitions for the chainable event counter pair.
// Assumes: exactly two lanes, event codes of 8 bits, 3-bit register addresses.
package evtcnt_pkg;
    localparam int NUM_LANES = 2;
    localparam int TYPE_W    = 8;
    localparam int ADDR_W    = 3;

    typedef logic [TYPE_W-1:0] evt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // event codes
    localparam evt_t EVT_SWINC = 8'h00;
    localparam evt_t EVT_CYCLE = 8'h11;
    localparam evt_t EVT_CHAIN = 8'h1E;

    // register addresses
    localparam addr_t ADR_CNT_BASE = 3'd0;  // 0 even, 1 odd
    localparam addr_t ADR_TYP_BASE = 3'd2;  // 2 even, 3 odd
    localparam addr_t ADR_ENSET    = 3'd4;
    localparam addr_t ADR_STATUS   = 3'd5;
endpackage

// File: rtl/evtcnt_lane.sv
// One counting lane: it selects its event source from its type code, gates it
// with the run and enable inputs, and raises a same-cycle wrap output when it
// rolls over from all-ones. Assumes the parent gives chain_in = 0 for a lane
// with no lane below it.
module evtcnt_lane
    import evtcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             lane_en,
    input  evt_t             evt_type,
    input  logic             cycle_tick,
    input  logic             sw_hit,
    input  logic             chain_in,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic event_hit;
    logic step;

    // Select the event source named by the type code.
    always_comb begin
        case (evt_type)
            EVT_CYCLE: event_hit = cycle_tick;
            EVT_SWINC: event_hit = sw_hit;
            EVT_CHAIN: event_hit = chain_in;
            default:   event_hit = 1'b0;
        endcase
    end

    // Count only when run and the lane enable allow it. A preset suppresses the wrap.
    always_comb begin
        step = run_en && lane_en && event_hit;
        wrap = step && (&count) && !preset_we;
    end

    // Count register: reset, then the preset, then the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (preset_we) count <= preset_val;
        else if (step)      count <= count + 1'b1;
    end

    // R11
    preset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(preset_we) |-> count == $past(preset_val));

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(preset_we) && !($past(run_en) && $past(lane_en))
        |-> count == $past(count));
endmodule

// File: rtl/evtcnt_ctrl.sv
// Control registers: the event type of each lane, the write-1-to-set enable
// bits and the write-1-to-clear overflow flags. A lane's wrap is reported on
// its own flag unless the lane above it is typed chain.
// Assumes the wrap inputs are same-cycle pulses from the lanes.
module evtcnt_ctrl
    import evtcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  addr_t                  reg_waddr,
    input  logic [CNT_W-1:0]       reg_wdata,
    input  logic [NUM_LANES-1:0]   wrap,
    output evt_t [NUM_LANES-1:0]   evt_type,
    output logic [NUM_LANES-1:0]   lane_en,
    output logic [NUM_LANES-1:0]   ovf
);
    logic en_wr;
    logic st_wr;
    logic [NUM_LANES-1:0] masked_above;
    logic [NUM_LANES-1:0] ovf_set;

    // Decode the shared register strobes.
    always_comb begin
        en_wr = reg_we && (reg_waddr == ADR_ENSET);
        st_wr = reg_we && (reg_waddr == ADR_STATUS);
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // A lane's overflow is hidden when the lane above it chains on it.
        if (i + 1 < NUM_LANES) begin : g_above
            always_comb masked_above[i] = (evt_type[i+1] == EVT_CHAIN);
        end else begin : g_top
            always_comb masked_above[i] = 1'b0;
        end

        // Work out the overflow set condition for this lane.
        always_comb ovf_set[i] = wrap[i] && !masked_above[i];

        // Event type register for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_type[i] <= EVT_SWINC;
            else if (reg_we && (reg_waddr == addr_t'(ADR_TYP_BASE + i)))
                evt_type[i] <= reg_wdata[TYPE_W-1:0];
        end

        // Enable bit, write-1-to-set.
        always_ff @(posedge clk) begin
            if (!rst_n)                    lane_en[i] <= 1'b0;
            else if (en_wr && reg_wdata[i]) lane_en[i] <= 1'b1;
        end

        // Overflow flag, write-1-to-clear; a new overflow wins over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          ovf[i] <= 1'b0;
            else if (ovf_set[i]) ovf[i] <= 1'b1;
            else if (st_wr && reg_wdata[i]) ovf[i] <= 1'b0;
        end

        // R9
        en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(lane_en[i]) |-> lane_en[i]);

        // R10
        ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(st_wr && reg_wdata[i] && !wrap[i]) |-> !ovf[i]);
    end

    // R6
    chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ovf[0]) && $past(evt_type[1] == EVT_CHAIN) |-> !ovf[0]);
endmodule

// File: rtl/evtcnt_pair.sv
// Top of the chainable event counter pair: two lanes, the control registers
// and the read mux. The even lane's wrap feeds the odd lane's chain input in
// the same cycle. Assumes CNT_W >= 8 so that type codes fit the read data.
module evtcnt_pair
    import evtcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cycle_tick,
    input  logic             swinc_valid,
    input  logic [1:0]       swinc_mask,
    input  logic             reg_we,
    input  logic [2:0]       reg_waddr,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic [2:0]       reg_raddr,
    output logic [CNT_W-1:0] reg_rdata
);
    logic [NUM_LANES-1:0][CNT_W-1:0] count;
    logic [NUM_LANES-1:0]            wrap;
    logic [NUM_LANES-1:0]            chain_in;
    logic [NUM_LANES-1:0]            lane_en;
    logic [NUM_LANES-1:0]            ovf;
    evt_t [NUM_LANES-1:0]            evt_type;

    evtcnt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .wrap      (wrap),
        .evt_type  (evt_type),
        .lane_en   (lane_en),
        .ovf       (ovf)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        // Chain source: the wrap of the lane below, or nothing for lane 0.
        if (i == 0) begin : g_bottom
            always_comb chain_in[i] = 1'b0;
        end else begin : g_upper
            always_comb chain_in[i] = wrap[i-1];
        end

        evtcnt_lane #(.CNT_W(CNT_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_en     (run_en),
            .lane_en    (lane_en[i]),
            .evt_type   (evt_type[i]),
            .cycle_tick (cycle_tick),
            .sw_hit     (swinc_valid && swinc_mask[i]),
            .chain_in   (chain_in[i]),
            .preset_we  (reg_we && (reg_waddr == addr_t'(ADR_CNT_BASE + i))),
            .preset_val (reg_wdata),
            .count      (count[i]),
            .wrap       (wrap[i])
        );
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            3'd0:       reg_rdata = count[0];
            3'd1:       reg_rdata = count[1];
            3'd2:       reg_rdata[TYPE_W-1:0] = evt_type[0];
            3'd3:       reg_rdata[TYPE_W-1:0] = evt_type[1];
            ADR_ENSET:  reg_rdata[NUM_LANES-1:0] = lane_en;
            ADR_STATUS: reg_rdata[NUM_LANES-1:0] = ovf;
            default:    reg_rdata = '0;
        endcase
    end

    // R6
    carry_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wrap[0] && evt_type[1] == EVT_CHAIN && lane_en[1]
                              && run_en && !(reg_we && reg_waddr == 3'd1))
        |-> count[1] == $past(count[1]) + 1'b1);

    // R7
    top_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wrap[1]) |-> ovf[1]);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (count == '0) && (ovf == '0) && (lane_en == '0));
endmodule

// File: tb/sim_evtcnt_pair.sv
module sim_evtcnt_pair;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         cycle_tick = 1'b0;
    logic         swinc_valid = 1'b0;
    logic [1:0]   swinc_mask = 2'b00;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_waddr = 3'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [2:0]   reg_raddr = 3'd0;
    logic [W-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    evtcnt_pair #(.CNT_W(W)) u0 (.*);

    always #4 clk = ~clk;  // 125 MHz

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input string what,
                          input logic [2:0] a, input logic [W-1:0] exp);
        reg_raddr = a;
        #1;
        chk(req, what, reg_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic sw_pulses(input logic [1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            swinc_valid = 1'b1; swinc_mask = m;
            step();
        end
        swinc_valid = 1'b0; swinc_mask = 2'b00;
    endtask

    task automatic ticks(input int n);
        cycle_tick = 1'b1;
        repeat (n) step();
        cycle_tick = 1'b0;
    endtask

    task automatic do_reset();
        run_en = 1'b0; cycle_tick = 1'b0; swinc_valid = 1'b0; reg_we = 1'b0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        wr(3'd0, 32'h1234); wr(3'd4, 32'h3); wr(3'd2, 32'h11);
        do_reset();
        for (int a = 0; a < 6; a++) rd_chk("R1", "reset value", 3'(a), 32'h0);
    endtask

    task automatic t_gating();
        do_reset();
        wr(3'd0, 32'hFFFF_FFF0); wr(3'd4, 32'h3);
        sw_pulses(2'b11, 100);
        rd_chk("R2", "run_en low even", 3'd0, 32'hFFFF_FFF0);
        rd_chk("R2", "run_en low odd", 3'd1, 32'h0);
        do_reset();
        wr(3'd4, 32'h1); run_en = 1'b1;
        sw_pulses(2'b11, 5);
        rd_chk("R2", "enabled even", 3'd0, 32'd5);
        rd_chk("R2", "disabled odd", 3'd1, 32'd0);
    endtask

    task automatic t_unchained_sw();
        do_reset();
        wr(3'd0, 32'hFFFF_FFF0); wr(3'd4, 32'h3); run_en = 1'b1;
        sw_pulses(2'b11, 100);
        rd_chk("R5", "even after 100", 3'd0, 32'd84);
        rd_chk("R5", "odd after 100", 3'd1, 32'd100);
        rd_chk("R5", "status", 3'd5, 32'h1);
        sw_pulses(2'b10, 3);
        rd_chk("R4", "mask bit 0 clear", 3'd0, 32'd84);
        rd_chk("R4", "mask bit 1 set", 3'd1, 32'd103);
    endtask

    task automatic t_types();
        do_reset();
        wr(3'd2, 32'h11); wr(3'd3, 32'h05); wr(3'd4, 32'h3); run_en = 1'b1;
        rd_chk("R11", "even type readback", 3'd2, 32'h11);
        ticks(10);
        sw_pulses(2'b11, 4);
        rd_chk("R3", "cycle type counts ticks", 3'd0, 32'd10);
        rd_chk("R4", "other code ignores sw", 3'd1, 32'd0);
        wr(3'd2, 32'h1E);
        ticks(6); sw_pulses(2'b01, 3);
        rd_chk("R3", "even chain counts nothing", 3'd0, 32'd10);
    endtask

    task automatic t_chain_tick();
        do_reset();
        wr(3'd2, 32'h11); wr(3'd3, 32'h1E); wr(3'd4, 32'h3);
        wr(3'd0, 32'hFFFF_FFF0); run_en = 1'b1;
        ticks(22);
        rd_chk("R6", "even after carry", 3'd0, 32'd6);
        rd_chk("R6", "odd got one carry", 3'd1, 32'd1);
        rd_chk("R6", "no even overflow", 3'd5, 32'h0);
        wr(3'd0, 32'hFFFF_FFF0); wr(3'd1, 32'hFFFF_FFFF);
        ticks(22);
        rd_chk("R7", "odd wrapped", 3'd1, 32'd0);
        rd_chk("R7", "status odd flag", 3'd5, 32'h2);
        wr(3'd5, 32'h1);
        rd_chk("R10", "clear of other bit", 3'd5, 32'h2);
        wr(3'd5, 32'h2);
        rd_chk("R10", "cleared", 3'd5, 32'h0);
    endtask

    task automatic t_chain_sw();
        do_reset();
        wr(3'd3, 32'h1E); wr(3'd0, 32'hFFFF_FFF0); wr(3'd4, 32'h3); run_en = 1'b1;
        sw_pulses(2'b11, 100);
        rd_chk("R8", "even", 3'd0, 32'd84);
        rd_chk("R8", "odd only carries", 3'd1, 32'd1);
        rd_chk("R8", "status", 3'd5, 32'h0);
    endtask

    task automatic t_enable();
        do_reset();
        wr(3'd4, 32'h1); wr(3'd4, 32'h2); wr(3'd4, 32'h0);
        rd_chk("R9", "sticky enables", 3'd4, 32'h3);
    endtask

    task automatic t_collisions();
        do_reset();
        wr(3'd4, 32'h3); wr(3'd0, 32'hFFFF_FFFF); run_en = 1'b1;
        // new overflow in the same cycle as a status clear
        swinc_valid = 1'b1; swinc_mask = 2'b01;
        reg_we = 1'b1; reg_waddr = 3'd5; reg_wdata = 32'h1;
        step();
        swinc_valid = 1'b0; reg_we = 1'b0;
        rd_chk("R10", "set wins over clear", 3'd5, 32'h1);
        rd_chk("R5", "even wrapped", 3'd0, 32'h0);
        // preset against an increment
        wr(3'd2, 32'h11);
        cycle_tick = 1'b1;
        reg_we = 1'b1; reg_waddr = 3'd0; reg_wdata = 32'h100;
        step();
        cycle_tick = 1'b0; reg_we = 1'b0;
        rd_chk("R11", "preset beats tick", 3'd0, 32'h100);
        // preset of the odd lane against a carry
        wr(3'd3, 32'h1E); wr(3'd0, 32'hFFFF_FFFF);
        cycle_tick = 1'b1;
        reg_we = 1'b1; reg_waddr = 3'd1; reg_wdata = 32'h55;
        step();
        cycle_tick = 1'b0; reg_we = 1'b0;
        rd_chk("R11", "preset beats carry", 3'd1, 32'h55);
        rd_chk("R6", "even wrapped under chain", 3'd0, 32'h0);
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        t_reset();
        t_gating();
        t_unchained_sw();
        t_types();
        t_chain_tick();
        t_chain_sw();
        t_enable();
        t_collisions();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule